// File: doc/BRIEF.md
# Static Memory Access Sequencer

This block controls a small static memory macro on behalf of a synchronous requester. The requester presents a read or write with a 5-bit word address while the ready output is high. The block latches the request and steps through four one-clock phases: bitline precharge and equalize, wordline raise, data transfer through either the sense amplifier or the write driver, and a completion cycle. A read result comes back with a one-cycle valid strobe. The block holds ready low until the access has finished.

The address splits into a row field, which is decoded to one of eight gated wordlines, and a column field, which is decoded to one of four column-mux selects. The column mux interleaves four words across each row. A behavioural model of the 512 bitcells (8 rows by 64 physical columns) sits inside the block. Every enable it drives can therefore be checked end to end through real data.

Top module: `sram_seq_top`

## Requirements
- R1: After reset, ready_o is 1 and precharge_o, wl_o, col_sel_o, wr_en_o, sense_en_o and rvalid_o are all 0.
- R2: A request is taken only on a clock edge where req_i and ready_o are both 1. ready_o then stays 0 for exactly four cycles. A request presented while ready_o is 0 is ignored and writes nothing.
- R3: In the four cycles after acceptance, the phases run in this order: cycle 1 precharge_o=1; cycle 2 the wordline only; cycle 3 the wordline together with the transfer enable; cycle 4 completion.
- R4: The row field addr_i[4:2] selects wl_o bit addr_i[4:2], one-hot. The column field addr_i[1:0] selects col_sel_o bit addr_i[1:0], one-hot, in cycle 3.
- R5: precharge_o is never 1 in the same cycle as a nonzero wl_o, wr_en_o or sense_en_o. wr_en_o and sense_en_o are never both 1.
- R6: wr_en_o is 1 only in cycle 3 of a write. sense_en_o is 1 only in cycle 3 of a read.
- R7: wl_o is zero outside cycles 2 and 3 of an access. col_sel_o is zero outside cycle 3.
- R8: A read returns the data most recently written to the same address. An address never written since reset reads as zero.
- R9: Word bit i is stored at physical column 4*i + addr_i[1:0] of the selected row. A write to one column select leaves the other three words of the same row unchanged.
- R10: rvalid_o is a one-cycle pulse in cycle 4 of a read only, and rdata_o carries the read word in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Word address: [4:2] row, [1:0] column |
| wdata_i | input | 16 | Write data |
| ready_o | output | 1 | Idle and able to take a request |
| precharge_o | output | 1 | Bitline precharge/equalize enable |
| wl_o | output | 8 | Gated wordlines, one-hot |
| col_sel_o | output | 4 | Column-mux selects, one-hot |
| wr_en_o | output | 1 | Write-driver enable |
| sense_en_o | output | 1 | Sense-amplifier enable |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | Read data valid strobe |

## Verification
A wrong phase state shows at once on the strobe outputs. Every access is therefore compared cycle by cycle across all five cycles it occupies, so a skipped, repeated or overlapping phase is seen in the cycle where it happens. A wrong decode or interleave mapping stays hidden until the damaged location is read back. For that reason every address is read before any write, written, and read again, and a full row is rewritten one column at a time to expose any disturbance of neighbouring words. A request that slips in while the block is busy shows up as corrupted data at a later read of the address it targeted.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_WL,
    PH_XFER,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/sram_seq_onehot.sv
module sram_seq_onehot #(
  parameter int N    = 8,
  localparam int IN_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic            en_i,
  input  logic [IN_W-1:0] sel_i,
  output logic [N-1:0]    dec_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    assign dec_o[g] = en_i && (sel_i == IN_W'(g));
  end
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int WORD_W = 16,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [WORD_W-1:0] sense_data_i,
  output logic              ready_o,
  output logic              precharge_o,
  output logic              wl_en_o,
  output logic              col_en_o,
  output logic              wr_en_o,
  output logic              sense_en_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  phase_e              phase_q, phase_d;
  logic [ADDR_W-1:0]   addr_q;
  logic                we_q;
  logic [WORD_W-1:0]   wdata_q, rdata_q;
  logic                accept;

  assign accept = req_i && (phase_q == PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE: if (req_i) phase_d = PH_PRE;
      PH_PRE:  phase_d = PH_WL;
      PH_WL:   phase_d = PH_XFER;
      PH_XFER: phase_d = PH_DONE;
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        addr_q  <= addr_i;
        we_q    <= we_i;
        wdata_q <= wdata_i;
      end
      // capture sensed word at the end of the sense phase
      if (phase_q == PH_XFER && !we_q) rdata_q <= sense_data_i;
    end
  end

  assign ready_o     = (phase_q == PH_IDLE);
  assign precharge_o = (phase_q == PH_PRE);
  assign wl_en_o     = (phase_q == PH_WL) || (phase_q == PH_XFER);
  assign col_en_o    = (phase_q == PH_XFER);
  assign wr_en_o     = (phase_q == PH_XFER) && we_q;
  assign sense_en_o  = (phase_q == PH_XFER) && !we_q;
  assign rvalid_o    = (phase_q == PH_DONE) && !we_q;
  assign row_o       = addr_q[ADDR_W-1:COL_W];
  assign col_o       = addr_q[COL_W-1:0];
  assign wdata_o     = wdata_q;
  assign rdata_o     = rdata_q;

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> (precharge_o && !ready_o));
  p_busy_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !rvalid_o && !precharge_o && !wl_en_o) |=> ready_o);
endmodule

// File: rtl/sram_seq_array.sv
module sram_seq_array #(
  parameter int ROWS   = 8,
  parameter int MUX    = 4,
  parameter int WORD_W = 16,
  localparam int PHYS_COLS = WORD_W * MUX
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROWS-1:0]   wl_i,
  input  logic [MUX-1:0]    col_sel_i,
  input  logic              wr_en_i,
  input  logic              sense_en_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] sense_data_o
);
  logic [PHYS_COLS-1:0] cells_q [ROWS];

  // word bit i lives at physical column i*MUX + column select
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) cells_q[r] <= '0;
    end else if (wr_en_i) begin
      for (int r = 0; r < ROWS; r++)
        for (int i = 0; i < WORD_W; i++)
          for (int m = 0; m < MUX; m++)
            if (wl_i[r] && col_sel_i[m]) cells_q[r][i*MUX+m] <= wdata_i[i];
    end
  end

  always_comb begin
    sense_data_o = '0;
    for (int r = 0; r < ROWS; r++)
      for (int i = 0; i < WORD_W; i++)
        for (int m = 0; m < MUX; m++)
          sense_data_o[i] = sense_data_o[i]
                          | (sense_en_i & wl_i[r] & col_sel_i[m] & cells_q[r][i*MUX+m]);
  end

  p_drive_needs_row_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i || sense_en_i) |-> ($countones(wl_i) == 1 && $countones(col_sel_i) == 1));
endmodule

// File: rtl/sram_seq_top.sv
module sram_seq_top #(
  parameter int ROWS   = 8,
  parameter int MUX    = 4,
  parameter int WORD_W = 16,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(MUX),
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              precharge_o,
  output logic [ROWS-1:0]   wl_o,
  output logic [MUX-1:0]    col_sel_o,
  output logic              wr_en_o,
  output logic              sense_en_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic              wl_en, col_en;
  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic [WORD_W-1:0] wdata_q, sense_data;

  sram_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W)) u_ctrl (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .sense_data_i(sense_data),
    .ready_o, .precharge_o,
    .wl_en_o(wl_en), .col_en_o(col_en),
    .wr_en_o, .sense_en_o,
    .row_o(row), .col_o(col),
    .wdata_o(wdata_q), .rdata_o, .rvalid_o
  );

  sram_seq_onehot #(.N(ROWS)) u_row_dec (.en_i(wl_en),  .sel_i(row), .dec_o(wl_o));
  sram_seq_onehot #(.N(MUX))  u_col_dec (.en_i(col_en), .sel_i(col), .dec_o(col_sel_o));

  sram_seq_array #(.ROWS(ROWS), .MUX(MUX), .WORD_W(WORD_W)) u_array (
    .clk_i, .rst_ni,
    .wl_i(wl_o), .col_sel_i(col_sel_o),
    .wr_en_i(wr_en_o), .sense_en_i(sense_en_o),
    .wdata_i(wdata_q), .sense_data_o(sense_data)
  );

  p_pre_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    precharge_o |-> (wl_o == '0 && !sense_en_o && !wr_en_o));
  p_sa_wd_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sense_en_o && wr_en_o));
  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wl_o) && $onehot0(col_sel_o));
  p_pre_then_wl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    precharge_o |=> (wl_o != '0 && col_sel_o == '0));
  p_xfer_after_wl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_en_o || wr_en_o) |-> (wl_o != '0 && $past(wl_o) == wl_o));
  p_col_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_sel_o != '0) |-> (wl_o != '0 && (sense_en_o || wr_en_o)));
  p_rvalid_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
  p_rvalid_after_sense_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(sense_en_o));
endmodule

// File: tb/sram_seq_top_test.sv
module sram_seq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        ready, precharge, wr_en, sense_en, rvalid;
  logic [7:0]  wl;
  logic [3:0]  col_sel;
  logic [15:0] rdata;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] model [32];

  always #10 clk = ~clk;

  sram_seq_top uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .precharge_o(precharge), .wl_o(wl),
    .col_sel_o(col_sel), .wr_en_o(wr_en), .sense_en_o(sense_en),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [4:0] a, input logic [15:0] d,
                        input bit intrude);
    logic [7:0] exp_wl;
    logic [3:0] exp_col;
    exp_wl  = 8'(1) << a[4:2];
    exp_col = 4'(1) << a[1:0];
    @(negedge clk);
    chk("R2 ready before request", 32'(ready), 1);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);  // cycle 1: precharge
    if (intrude) begin
      we = 1'b1; addr = a ^ 5'h01; wdata = 16'hDEAD;
    end else req = 1'b0;
    chk("R2 busy c1", 32'(ready), 0);
    chk("R3 precharge c1", 32'(precharge), 1);
    chk("R7 wl idle c1", 32'(wl), 0);
    chk("R5 drivers off c1", {30'b0, wr_en, sense_en}, 0);
    @(negedge clk);  // cycle 2: wordline
    chk("R3 precharge off c2", 32'(precharge), 0);
    chk("R4 wl c2", 32'(wl), 32'(exp_wl));
    chk("R7 col off c2", 32'(col_sel), 0);
    chk("R6 drivers off c2", {30'b0, wr_en, sense_en}, 0);
    @(negedge clk);  // cycle 3: transfer
    chk("R4 wl c3", 32'(wl), 32'(exp_wl));
    chk("R4 col c3", 32'(col_sel), 32'(exp_col));
    chk("R6 wr_en c3", 32'(wr_en), 32'(w));
    chk("R6 sense_en c3", 32'(sense_en), 32'(!w));
    chk("R5 precharge off c3", 32'(precharge), 0);
    chk("R2 busy c3", 32'(ready), 0);
    if (w) model[a] = d;
    @(negedge clk);  // cycle 4: done
    req = 1'b0;
    chk("R7 wl off c4", 32'(wl), 0);
    chk("R7 col off c4", 32'(col_sel), 0);
    chk("R10 rvalid c4", 32'(rvalid), 32'(!w));
    if (!w) chk($sformatf("R8 R9 rdata addr %0d", a), 32'(rdata), 32'(model[a]));
    @(negedge clk);
    chk("R2 ready after four cycles", 32'(ready), 1);
    chk("R10 rvalid single pulse", 32'(rvalid), 0);
    chk("R7 wl after access", 32'(wl), 0);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(ready), 1);
    chk("R1 enables", {26'b0, precharge, wr_en, sense_en, rvalid, 2'b0}, 0);
    chk("R1 wl", 32'(wl), 0);
    chk("R1 col", 32'(col_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after release", 32'(ready), 1);

    // R8 unwritten reads return zero
    for (int a = 0; a < 32; a++) access(1'b0, 5'(a), '0, 1'b0);
    // full write then readback
    for (int a = 0; a < 32; a++)
      access(1'b1, 5'(a), 16'((a * 16'h3b1d) ^ 16'h5ac3), 1'b0);
    for (int a = 0; a < 32; a++) access(1'b0, 5'(a), '0, 1'b0);

    // R9 interleave: rewrite row 5 column by column, checking neighbours
    for (int c = 0; c < 4; c++) access(1'b1, 5'(20 + c), '0, 1'b0);
    access(1'b1, 5'(22), 16'hFFFF, 1'b0);
    for (int c = 0; c < 4; c++) access(1'b0, 5'(20 + c), '0, 1'b0);
    access(1'b1, 5'(21), 16'hA5A5, 1'b0);
    for (int c = 0; c < 4; c++) access(1'b0, 5'(20 + c), '0, 1'b0);

    // R2 requests held during busy are ignored
    access(1'b1, 5'd8, 16'h1234, 1'b1);
    access(1'b0, 5'd9, '0, 1'b1);
    access(1'b0, 5'd8, '0, 1'b0);
    access(1'b0, 5'd9, '0, 1'b0);

    // R8 overwrite returns the latest value
    access(1'b1, 5'd31, 16'h0F0F, 1'b0);
    access(1'b1, 5'd31, 16'hF00D, 1'b0);
    access(1'b0, 5'd31, '0, 1'b0);
    access(1'b0, 5'd30, '0, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule